// File: doc/BRIEF.md
# STS-12 Pointer Interpreter (Three-State)

This block follows the payload pointer of every STS-1 carried in a byte-interleaved STS-12 stream. Upstream framing logic presents one byte per cycle, tagged with its row, its column inside the STS-1 and the index of the STS-1 it belongs to. In the fourth row (row index 3), column 0 of each STS-1 holds the first pointer byte and column 1 holds the second. The block sorts each pointer word into one of three classes: normal, alarm-indication, or concatenation. It then runs a small per-STS machine that has only three states: NORM, AIS and CONC.

The result for each STS-1 is its accepted payload offset, an AIS flag and a concatenation flag. The block also produces two registered byte markers for downstream payload extraction. The first, an SPE-valid marker, flags payload columns of STS-1s that are not in alarm. The second, a C1J1 marker, flags the start-of-frame overhead byte of the first STS-1 and the path-overhead start byte of each STS-1 in NORM state. With these two markers a later stage can pick out the payload without decoding pointers again.

Top module: `ptr_interp_sts12`

## Requirements
- R1: After synchronous reset every STS-1 reports AIS flag 1, concatenation flag 0 and offset 0, and both markers are 0.
- R2: For STS-1 s, the first pointer byte (P1) is sampled when in_valid is high at row 3, column 0. The second byte (P2) is taken at row 3, column 1. The offset is {P1[1:0], P2} and the N field is P1[7:4]. The per-STS outputs change only on the clock edge that takes a second pointer byte.
- R3: A pointer is normal when its offset is at most 782 and its N field is 0110 or 1001. When an STS-1 not in NORM receives two consecutive normal pointers, it enters NORM with the offset of the second one. In NORM both flags are 0.
- R4: In NORM, two consecutive normal pointers replace the offset with the later value only if both differ from the current offset. Otherwise the offset is kept.
- R5: A pointer is AIS when the N field is 1111 and the offset is 0x3FF, with bits P1[3:2] ignored. Three consecutive AIS pointers set the AIS flag, clear the concatenation flag and keep the offset.
- R6: A pointer is concatenation when the offset is 0x3FF and the N field is 1001 or differs from 1001 in one bit. Three consecutive ones set the concatenation flag, clear the AIS flag and keep the offset.
- R7: A pointer of no class changes neither state nor offset, and it breaks any run of consecutive pointers.
- R8: Pointers received for one STS-1 leave the state and offset of every other STS-1 unchanged.
- R9: spe_valid is 1 in the cycle after a valid byte exactly when the byte's column is 3 or more and its STS-1 does not have the AIS flag set.
- R10: c1j1_mark is 1 in the cycle after a valid byte exactly in two cases. The first is STS-1 0 at row 0, column 2. The second is an STS-1 in NORM with offset o, at row (3 + o div 87) mod 9 and column 3 + (o mod 87). The marker is 0 after a cycle with in_valid low.
- R11: The AIS and concatenation flags of an STS-1 are never set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte and position tags are valid |
| in_byte | input | 8 | Incoming stream byte |
| in_row | input | ROW_W (4) | Row index 0..8 |
| in_col | input | COL_W (7) | Column index inside the STS-1, 0..89 |
| in_sts | input | STS_W (4) | STS-1 index 0..11 |
| ptr_offset | output | NUM_STS*10 (120) | Accepted offset per STS-1, STS-1 s at bits [10s+9:10s] |
| ptr_ais | output | NUM_STS (12) | AIS flag per STS-1 |
| ptr_conc | output | NUM_STS (12) | Concatenation flag per STS-1 |
| spe_valid | output | 1 | Payload marker for the previous valid byte |
| c1j1_mark | output | 1 | Frame-start or path-start marker for the previous valid byte |

## Verification
Pointer acceptance and the C1J1 marker can act on the same STS-1 within one row. A new offset below 84 puts the path start in row 3, just a few bytes after the second pointer byte that set it. The bench changes an offset and then probes that row, and expects the marker to follow the new offset with no frame of lag. The acceptance rule for NORM is also provoked with pairs in which only one pointer differs from the current offset, and with runs broken by invalid pointers. The results are judged against a per-STS reference model in the bench.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int PTR_OFF_W = 10;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_AIS  = 2'd1,
    ST_CONC = 2'd2
  } pi_state_e;

  typedef enum logic [1:0] {
    PC_NONE = 2'd0,
    PC_NORM = 2'd1,
    PC_AIS  = 2'd2,
    PC_CONC = 2'd3
  } pi_class_e;
endpackage

// File: rtl/pi_classify.sv
module pi_classify
  import pi_pkg::*;
#(
  parameter int MAX_OFF = 782
) (
  input  logic [7:0]           p1,
  input  logic [7:0]           p2,
  output pi_class_e            cls,
  output logic [PTR_OFF_W-1:0] off
);
  logic [3:0] nfield;
  logic [2:0] ndf_dist;
  logic       off_ones;

  assign off      = {p1[1:0], p2};
  assign nfield   = p1[7:4];
  assign ndf_dist = 3'($countones(nfield ^ 4'b1001));
  assign off_ones = (off == '1);

  always_comb begin
    cls = PC_NONE;
    if (nfield == 4'hF && off_ones)
      cls = PC_AIS;
    else if (ndf_dist <= 3'd1 && off_ones)
      cls = PC_CONC;
    else if ((off <= PTR_OFF_W'(MAX_OFF)) && (nfield == 4'b0110 || nfield == 4'b1001))
      cls = PC_NORM;
  end
endmodule

// File: rtl/pi_sts_fsm.sv
module pi_sts_fsm
  import pi_pkg::*;
#(
  parameter int NORM_RUN = 2,
  parameter int AIS_RUN  = 3,
  parameter int CONC_RUN = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  pi_class_e            cls,
  input  logic [PTR_OFF_W-1:0] rx_off,
  output pi_state_e            state,
  output logic [PTR_OFF_W-1:0] offset
);
  localparam int RUN_MAX = (NORM_RUN > AIS_RUN) ? ((NORM_RUN > CONC_RUN) ? NORM_RUN : CONC_RUN)
                                                : ((AIS_RUN > CONC_RUN) ? AIS_RUN : CONC_RUN);
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  pi_class_e            last_cls;
  logic [RUN_W-1:0]     run_q, run_nx;
  logic [PTR_OFF_W-1:0] prev_off;

  always_comb begin
    if (cls == PC_NONE)
      run_nx = '0;
    else if (cls == last_cls)
      run_nx = (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + 1'b1;
    else
      run_nx = RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_AIS;
      offset   <= '0;
      last_cls <= PC_NONE;
      run_q    <= '0;
      prev_off <= '0;
    end else if (upd) begin
      last_cls <= cls;
      run_q    <= run_nx;
      if (cls == PC_NORM)
        prev_off <= rx_off;
      case (cls)
        PC_NORM: begin
          if (run_nx >= RUN_W'(NORM_RUN)) begin
            if (state != ST_NORM) begin
              state  <= ST_NORM;
              offset <= rx_off;
            end else if (prev_off != offset && rx_off != offset) begin
              offset <= rx_off;
            end
          end
        end
        PC_AIS:  if (run_nx >= RUN_W'(AIS_RUN))  state <= ST_AIS;
        PC_CONC: if (run_nx >= RUN_W'(CONC_RUN)) state <= ST_CONC;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pi_marker.sv
module pi_marker
  import pi_pkg::*;
#(
  parameter int NUM_STS  = 12,
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int TOH_COLS = 3,
  parameter int PTR_ROW  = 3,
  parameter int ROW_W    = $clog2(ROWS),
  parameter int COL_W    = $clog2(COLS),
  parameter int STS_W    = $clog2(NUM_STS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [ROW_W-1:0]             in_row,
  input  logic [COL_W-1:0]             in_col,
  input  logic [STS_W-1:0]             in_sts,
  input  logic [NUM_STS*PTR_OFF_W-1:0] tbl_off,
  input  logic [NUM_STS-1:0]           tbl_ais,
  input  logic [NUM_STS-1:0]           tbl_conc,
  output logic                         spe_valid,
  output logic                         c1j1_mark
);
  localparam int SPE_COLS = COLS - TOH_COLS;

  logic                 sts_ok;
  logic [PTR_OFF_W-1:0] sel_off;
  logic                 sel_ais, sel_norm;
  logic                 spe_d, c1_hit, j1_hit;

  assign sts_ok   = (int'(in_sts) < NUM_STS);
  assign sel_off  = sts_ok ? tbl_off[in_sts*PTR_OFF_W +: PTR_OFF_W] : '0;
  assign sel_ais  = sts_ok && tbl_ais[in_sts];
  assign sel_norm = sts_ok && !tbl_ais[in_sts] && !tbl_conc[in_sts];

  always_comb begin
    int o, q, jr, jc;
    o = int'(sel_off);
    q = 0;
    for (int k = 1; k < ROWS; k++)
      if (o >= k * SPE_COLS) q = k;
    jr = (PTR_ROW + q) % ROWS;
    jc = TOH_COLS + o - q * SPE_COLS;
    j1_hit = sel_norm && (int'(in_row) == jr) && (int'(in_col) == jc);
  end

  assign c1_hit = (in_sts == '0) && (in_row == '0) && (int'(in_col) == TOH_COLS - 1);
  assign spe_d  = sts_ok && (int'(in_col) >= TOH_COLS) && !sel_ais;

  always_ff @(posedge clk) begin
    if (rst) begin
      spe_valid <= 1'b0;
      c1j1_mark <= 1'b0;
    end else begin
      spe_valid <= in_valid && spe_d;
      c1j1_mark <= in_valid && (c1_hit || j1_hit);
    end
  end
endmodule

// File: rtl/ptr_interp_sts12.sv
module ptr_interp_sts12
  import pi_pkg::*;
#(
  parameter int NUM_STS  = 12,
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int TOH_COLS = 3,
  parameter int PTR_ROW  = 3,
  parameter int MAX_OFF  = 782,
  parameter int NORM_RUN = 2,
  parameter int AIS_RUN  = 3,
  parameter int CONC_RUN = 3,
  parameter int ROW_W    = $clog2(ROWS),
  parameter int COL_W    = $clog2(COLS),
  parameter int STS_W    = $clog2(NUM_STS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [7:0]                   in_byte,
  input  logic [ROW_W-1:0]             in_row,
  input  logic [COL_W-1:0]             in_col,
  input  logic [STS_W-1:0]             in_sts,
  output logic [NUM_STS*PTR_OFF_W-1:0] ptr_offset,
  output logic [NUM_STS-1:0]           ptr_ais,
  output logic [NUM_STS-1:0]           ptr_conc,
  output logic                         spe_valid,
  output logic                         c1j1_mark
);
  logic                 sts_ok, p1_hit, p2_hit;
  logic [7:0]           p1_mem [NUM_STS];
  logic [7:0]           p1_rd;
  pi_class_e            cls;
  logic [PTR_OFF_W-1:0] rx_off;

  assign sts_ok = (int'(in_sts) < NUM_STS);
  assign p1_hit = in_valid && sts_ok && (int'(in_row) == PTR_ROW) && (in_col == COL_W'(0));
  assign p2_hit = in_valid && sts_ok && (int'(in_row) == PTR_ROW) && (in_col == COL_W'(1));

  always_ff @(posedge clk) begin
    if (p1_hit)
      p1_mem[in_sts] <= in_byte;
  end

  assign p1_rd = sts_ok ? p1_mem[in_sts] : 8'h00;

  pi_classify #(.MAX_OFF(MAX_OFF)) u_cls (
    .p1 (p1_rd),
    .p2 (in_byte),
    .cls(cls),
    .off(rx_off)
  );

  for (genvar i = 0; i < NUM_STS; i++) begin : g_sts
    pi_state_e            st_i;
    logic [PTR_OFF_W-1:0] off_i;
    logic                 upd_i;

    assign upd_i = p2_hit && (int'(in_sts) == i);

    pi_sts_fsm #(
      .NORM_RUN(NORM_RUN),
      .AIS_RUN (AIS_RUN),
      .CONC_RUN(CONC_RUN)
    ) u_fsm (
      .clk   (clk),
      .rst   (rst),
      .upd   (upd_i),
      .cls   (cls),
      .rx_off(rx_off),
      .state (st_i),
      .offset(off_i)
    );

    assign ptr_offset[i*PTR_OFF_W +: PTR_OFF_W] = off_i;
    assign ptr_ais[i]  = (st_i == ST_AIS);
    assign ptr_conc[i] = (st_i == ST_CONC);
  end

  pi_marker #(
    .NUM_STS (NUM_STS),
    .ROWS    (ROWS),
    .COLS    (COLS),
    .TOH_COLS(TOH_COLS),
    .PTR_ROW (PTR_ROW),
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .STS_W   (STS_W)
  ) u_mark (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_row   (in_row),
    .in_col   (in_col),
    .in_sts   (in_sts),
    .tbl_off  (ptr_offset),
    .tbl_ais  (ptr_ais),
    .tbl_conc (ptr_conc),
    .spe_valid(spe_valid),
    .c1j1_mark(c1j1_mark)
  );
endmodule

// File: rtl/pi_checker.sv
module pi_checker
  import pi_pkg::*;
#(
  parameter int NUM_STS  = 12,
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int TOH_COLS = 3,
  parameter int PTR_ROW  = 3,
  parameter int MAX_OFF  = 782,
  parameter int ROW_W    = $clog2(ROWS),
  parameter int COL_W    = $clog2(COLS),
  parameter int STS_W    = $clog2(NUM_STS)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic [7:0]                   in_byte,
  input logic [ROW_W-1:0]             in_row,
  input logic [COL_W-1:0]             in_col,
  input logic [STS_W-1:0]             in_sts,
  input logic [NUM_STS*PTR_OFF_W-1:0] ptr_offset,
  input logic [NUM_STS-1:0]           ptr_ais,
  input logic [NUM_STS-1:0]           ptr_conc,
  input logic                         spe_valid,
  input logic                         c1j1_mark
);
  logic ptr_slot, toh_byte, ais_byte;

  assign ptr_slot = in_valid && (int'(in_row) == PTR_ROW) && (in_col == COL_W'(1));
  assign toh_byte = in_valid && (int'(in_col) < TOH_COLS);
  assign ais_byte = in_valid && (int'(in_sts) < NUM_STS) && ptr_ais[in_sts];

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(ptr_slot) |-> ($stable(ptr_offset) && $stable(ptr_ais) && $stable(ptr_conc))); // R2

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    (ptr_ais & ptr_conc) == '0); // R11

  AST_SPE_TOH: assert property (@(posedge clk) disable iff (rst)
    $past(toh_byte) |-> !spe_valid); // R9

  AST_SPE_AIS: assert property (@(posedge clk) disable iff (rst)
    $past(ais_byte) |-> !spe_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid) |-> (!spe_valid && !c1j1_mark)); // R10

  for (genvar i = 0; i < NUM_STS; i++) begin : g_chk
    AST_NORM_RANGE: assert property (@(posedge clk) disable iff (rst)
      (!ptr_ais[i] && !ptr_conc[i]) |-> (ptr_offset[i*PTR_OFF_W +: PTR_OFF_W] <= PTR_OFF_W'(MAX_OFF))); // R3
    AST_AIS_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst)
      $rose(ptr_ais[i]) |-> $stable(ptr_offset[i*PTR_OFF_W +: PTR_OFF_W])); // R5
  end
endmodule

bind ptr_interp_sts12 pi_checker #(
  .NUM_STS (NUM_STS),
  .ROWS    (ROWS),
  .COLS    (COLS),
  .TOH_COLS(TOH_COLS),
  .PTR_ROW (PTR_ROW),
  .MAX_OFF (MAX_OFF),
  .ROW_W   (ROW_W),
  .COL_W   (COL_W),
  .STS_W   (STS_W)
) u_chk (.*);

// File: tb/ptr_interp_sts12_bench.sv
module ptr_interp_sts12_bench;
  localparam int NS = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [3:0]  in_row = '0;
  logic [6:0]  in_col = '0;
  logic [3:0]  in_sts = '0;
  logic [NS*10-1:0] ptr_offset;
  logic [NS-1:0] ptr_ais, ptr_conc;
  logic        spe_valid, c1j1_mark;

  int n_tests = 0;
  int n_fail  = 0;

  // model: state 0 NORM, 1 AIS, 2 CONC ; class 0 none, 1 norm, 2 ais, 3 conc
  int m_st [NS];
  int m_off[NS];
  int m_last[NS];
  int m_run[NS];
  int m_prev[NS];

  always #10 clk = ~clk;

  ptr_interp_sts12 u_ptr_interp_sts12 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_row(in_row), .in_col(in_col), .in_sts(in_sts),
    .ptr_offset(ptr_offset), .ptr_ais(ptr_ais), .ptr_conc(ptr_conc),
    .spe_valid(spe_valid), .c1j1_mark(c1j1_mark)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_class(input logic [7:0] p1, input logic [7:0] p2);
    int off, n, d;
    off = {p1[1:0], p2};
    n   = p1[7:4];
    d   = $countones(4'(n) ^ 4'b1001);
    if (n == 15 && off == 1023) return 2;
    if (d <= 1 && off == 1023) return 3;
    if (off <= 782 && (n == 4'b0110 || n == 4'b1001)) return 1;
    return 0;
  endfunction

  task automatic model_upd(input int s, input logic [7:0] p1, input logic [7:0] p2);
    int c, r, off;
    c = ref_class(p1, p2);
    off = {p1[1:0], p2};
    if (c == 0) r = 0;
    else if (c == m_last[s]) r = (m_run[s] >= 3) ? 3 : m_run[s] + 1;
    else r = 1;
    if (c == 1 && r >= 2) begin
      if (m_st[s] != 0) begin m_st[s] = 0; m_off[s] = off; end
      else if (m_prev[s] != m_off[s] && off != m_off[s]) m_off[s] = off;
    end
    if (c == 2 && r >= 3) m_st[s] = 1;
    if (c == 3 && r >= 3) m_st[s] = 2;
    if (c == 1) m_prev[s] = off;
    m_last[s] = c;
    m_run[s]  = r;
  endtask

  task automatic send_ptr(input int s, input logic [3:0] n, input logic [1:0] ss, input logic [9:0] off);
    logic [7:0] p1;
    p1 = {n, ss, off[9:8]};
    @(negedge clk);
    in_valid = 1'b1; in_row = 4'd3; in_col = 7'd0; in_sts = 4'(s); in_byte = p1;
    @(negedge clk);
    in_col = 7'd1; in_byte = off[7:0];
    @(negedge clk);
    in_valid = 1'b0;
    model_upd(s, p1, off[7:0]);
  endtask

  task automatic check_table(input string tag);
    for (int s = 0; s < NS; s++) begin
      check(int'(ptr_offset[s*10 +: 10]) == m_off[s], {tag, " offset"}, int'(ptr_offset[s*10 +: 10]), m_off[s]);
      check(ptr_ais[s] == (m_st[s] == 1), {tag, " ais"}, int'(ptr_ais[s]), int'(m_st[s] == 1));
      check(ptr_conc[s] == (m_st[s] == 2), {tag, " conc"}, int'(ptr_conc[s]), int'(m_st[s] == 2));
    end
  endtask

  function automatic bit exp_c1j1(input int r, input int c, input int s);
    if (s == 0 && r == 0 && c == 2) return 1'b1;
    if (m_st[s] != 0) return 1'b0;
    return (r == (3 + m_off[s] / 87) % 9) && (c == 3 + m_off[s] % 87);
  endfunction

  task automatic probe(input int r, input int c, input int s, input string tag);
    bit es, ej;
    es = (c >= 3) && (m_st[s] != 1);
    ej = exp_c1j1(r, c, s);
    @(negedge clk);
    in_valid = 1'b1; in_row = 4'(r); in_col = 7'(c); in_sts = 4'(s); in_byte = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    check(spe_valid == es, {tag, " R9 spe_valid"}, int'(spe_valid), int'(es));
    check(c1j1_mark == ej, {tag, " R10 c1j1_mark"}, int'(c1j1_mark), int'(ej));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int s = 0; s < NS; s++) begin
      m_st[s] = 1; m_off[s] = 0; m_last[s] = 0; m_run[s] = 0; m_prev[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_table("R1 reset");
    check(spe_valid == 1'b0 && c1j1_mark == 1'b0, "R1 markers", int'({spe_valid, c1j1_mark}), 0);

    // R3 two normal pointers needed
    send_ptr(0, 4'b0110, 2'b10, 10'd100);
    check(ptr_ais[0] == 1'b1, "R3 one normal pointer not enough", int'(ptr_ais[0]), 1);
    send_ptr(0, 4'b0110, 2'b10, 10'd100);
    check_table("R3 NORM entry");
    send_ptr(7, 4'b1001, 2'b00, 10'd782);
    send_ptr(7, 4'b0110, 2'b00, 10'd782);
    check_table("R3 max offset with NDF first");

    // R4 acceptance needs both to differ
    send_ptr(0, 4'b0110, 2'b10, 10'd200);
    send_ptr(0, 4'b0110, 2'b10, 10'd100);
    check(int'(ptr_offset[9:0]) == 100, "R4 one differs kept", int'(ptr_offset[9:0]), 100);
    send_ptr(0, 4'b0110, 2'b10, 10'd300);
    send_ptr(0, 4'b0110, 2'b10, 10'd300);
    check(int'(ptr_offset[9:0]) == 300, "R4 both differ same", int'(ptr_offset[9:0]), 300);
    send_ptr(0, 4'b0110, 2'b10, 10'd400);
    send_ptr(0, 4'b0110, 2'b10, 10'd500);
    check(int'(ptr_offset[9:0]) == 500, "R4 both differ takes last", int'(ptr_offset[9:0]), 500);
    check_table("R4 R8 table");

    // R5 AIS after three, SS ignored
    send_ptr(0, 4'hF, 2'b01, 10'h3FF);
    send_ptr(0, 4'hF, 2'b10, 10'h3FF);
    check(ptr_ais[0] == 1'b0, "R5 two AIS not enough", int'(ptr_ais[0]), 0);
    send_ptr(0, 4'hF, 2'b11, 10'h3FF);
    check_table("R5 AIS entry");

    // R6 concatenation with single bit error
    send_ptr(2, 4'b0110, 2'b10, 10'd5);
    send_ptr(2, 4'b0110, 2'b10, 10'd5);
    send_ptr(2, 4'b1011, 2'b00, 10'h3FF);
    send_ptr(2, 4'b1001, 2'b00, 10'h3FF);
    check(ptr_conc[2] == 1'b0, "R6 two CONC not enough", int'(ptr_conc[2]), 0);
    send_ptr(2, 4'b0001, 2'b00, 10'h3FF);
    check_table("R6 CONC entry");

    // R7 invalid pointer breaks run
    send_ptr(3, 4'b0110, 2'b10, 10'd10);
    send_ptr(3, 4'b0110, 2'b10, 10'd10);
    send_ptr(3, 4'b0110, 2'b10, 10'd20);
    send_ptr(3, 4'b0110, 2'b10, 10'd800);
    send_ptr(3, 4'b0110, 2'b10, 10'd20);
    check(int'(ptr_offset[39:30]) == 10, "R7 broken run ignored", int'(ptr_offset[39:30]), 10);
    send_ptr(3, 4'b0000, 2'b10, 10'd50);
    check_table("R7 R8 invalid");

    // R9 R10 markers, with acceptance and marker in the same row
    send_ptr(4, 4'b0110, 2'b10, 10'd0);
    send_ptr(4, 4'b0110, 2'b10, 10'd0);
    probe(3, 3, 4, "J1 offset0");
    probe(3, 2, 4, "H3 column");
    probe(0, 2, 0, "C1 sts0");
    probe(0, 2, 1, "C1 sts1");
    send_ptr(5, 4'b0110, 2'b10, 10'd782);
    send_ptr(5, 4'b0110, 2'b10, 10'd782);
    probe(2, 89, 5, "J1 offset782");
    probe(2, 88, 5, "near J1");
    send_ptr(6, 4'b0110, 2'b10, 10'd87);
    send_ptr(6, 4'b0110, 2'b10, 10'd87);
    probe(4, 3, 6, "J1 offset87");
    probe(5, 40, 0, "AIS sts");
    probe(5, 40, 2, "CONC sts");

    // constrained random
    for (int it = 0; it < 600; it++) begin
      int s, k, off;
      s = $urandom_range(NS - 1);
      k = $urandom_range(9);
      off = (k < 2) ? m_off[s] : 100 * $urandom_range(7);
      if (k < 5) send_ptr(s, ($urandom_range(1) != 0) ? 4'b0110 : 4'b1001, 2'($urandom_range(3)), 10'(off));
      else if (k < 7) send_ptr(s, 4'hF, 2'($urandom_range(3)), 10'h3FF);
      else if (k < 9) send_ptr(s, 4'b1001 ^ (4'b0001 << $urandom_range(3)), 2'b00, 10'h3FF);
      else send_ptr(s, 4'b0110, 2'b00, 10'(783 + $urandom_range(200)));
      if (it % 20 == 19) check_table("R8 random table");
      if (it % 7 == 3) begin
        if ($urandom_range(1) != 0 && m_st[s] == 0)
          probe((3 + m_off[s] / 87) % 9, 3 + m_off[s] % 87, s, "random J1");
        else
          probe($urandom_range(8), $urandom_range(89), s, "random byte");
      end
    end
    check_table("R3 R5 R6 final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule